// File: doc/BRIEF.md
# Passive-Matrix Panel Timing Generator

This block produces the scan timing for a passive-matrix (STN) display driver from the system clock. Each line opens with a line-sync pulse. A programmable quiet delay follows, and then an active window in which a divided pixel clock toggles while a data-valid strobe is high. An optional blank tail closes the line. A frame is a programmable number of such lines, and the frame-sync output covers the whole of the first one. An AC-bias output inverts either once per frame or after every programmable number of lines, so the panel drive polarity alternates.

All timing values are static configuration inputs. The block copies them into shadow registers in the first cycle of every frame, so software may rewrite them at any time without disturbing the frame in progress. The pixel data path, memory fetch and register access are outside the block.

Top module: `stn_timing_gen`

## Requirements
- R1: One pixel-clock period is 2×D system-clock cycles, where D is `cfg_clkdiv` and any value below 2 counts as 2. In each period `pclk_o` is low for the first D cycles and high for the last D cycles, so each line has `cfg_hcount`+1 rising edges and (`cfg_hcount`+1)×D high cycles.
- R2: `valid_o` is high for exactly (`cfg_hcount`+1)×2×D consecutive cycles in each line.
- R3: Each line starts with `line_o` high for exactly 2^(4+`cfg_pulse_code`) cycles.
- R4: Between the fall of `line_o` and the rise of `valid_o` there are exactly 2^(4+`cfg_delay_code`) cycles. `pclk_o` is low whenever `valid_o` is low, and `valid_o` is never high together with `line_o`.
- R5: After the active window come 8×`cfg_blank` blank cycles. A value of 0 gives no blank period. The line length is the sum of the pulse, delay, active and blank cycles.
- R6: A frame holds `cfg_vcount`+1 lines. `frame_o` is high for every cycle of the first line of each frame and low during the other lines.
- R7: With `cfg_bias_mode`=0, `bias_o` inverts only at frame boundaries, so the frame with index f after reset has `bias_o` = f mod 2. `bias_o` changes only on the first cycle of a line.
- R8: With `cfg_bias_mode`=1, `bias_o` inverts after every M lines, where M is `cfg_bias_lines` and 0 counts as 1. The line count carries across frame boundaries, so the line with index k after reset has `bias_o` = floor(k/M) mod 2.
- R9: The configuration is captured in the first cycle of each frame. A change applied later in a frame takes effect only from the next frame on.
- R10: While `rst_n` is low (synchronous, active low), `bias_o`, `pclk_o` and `valid_o` are low and `line_o` and `frame_o` are high. The first cycle after reset is the first cycle of line 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_clkdiv | input | CLKDIV_W | Pixel clock divisor D |
| cfg_hcount | input | HOZ_W | Pixel-clock periods per line minus 1 |
| cfg_vcount | input | LINE_W | Lines per frame minus 1 |
| cfg_pulse_code | input | 2 | Line pulse width code |
| cfg_delay_code | input | 2 | Delay code between the line pulse and the active window |
| cfg_blank | input | BLANK_W | Blank length in units of 8 cycles |
| cfg_bias_mode | input | 1 | 0: bias toggles per frame, 1: bias toggles per M lines |
| cfg_bias_lines | input | MVAL_W | Line count M for bias mode 1 |
| frame_o | output | 1 | Frame sync, high during line 0 |
| line_o | output | 1 | Line sync pulse |
| pclk_o | output | 1 | Pixel clock |
| bias_o | output | 1 | AC-bias polarity |
| valid_o | output | 1 | Active data window strobe |

## Verification
A wrong phase counter or a wrong phase length shows up within a single line as a pulse, delay, window or blank width that differs from the value computed from the configuration. The scoreboard measures every line from one rise of `line_o` to the next, so it reports such a fault at the end of the line where it occurs. A wrong line counter or bias counter does not corrupt the line widths. It shows instead as `frame_o` on the wrong line, or `bias_o` inverting one line early or late, which is visible within one frame or within M lines. A shadow capture in the wrong cycle stays hidden until the configuration changes in the middle of a frame. The bench therefore makes such a change and checks the line shapes on both sides of the next frame boundary.

// File: rtl/stn_tg_pkg.sv
package stn_tg_pkg;

  typedef enum logic [1:0] {
    PH_PULSE  = 2'd0,
    PH_DELAY  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_BLANK  = 2'd3
  } line_phase_e;

  // Width of the line pulse in system-clock cycles.
  function automatic int unsigned pulse_cycles(input logic [1:0] code);
    return 32'd16 << code;
  endfunction

  // Quiet cycles from the end of the pulse to the first active cycle.
  function automatic int unsigned delay_cycles(input logic [1:0] code);
    return 32'd16 << code;
  endfunction

  // Blank tail in cycles.
  function automatic int unsigned blank_cycles(input int unsigned units);
    return units * 32'd8;
  endfunction

  // Divisor floor of two.
  function automatic int unsigned sat_divisor(input int unsigned v);
    return (v < 32'd2) ? 32'd2 : v;
  endfunction

  // Bias line count floor of one.
  function automatic int unsigned sat_bias_lines(input int unsigned v);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

endpackage

// File: rtl/stn_cfg_shadow.sv
module stn_cfg_shadow #(
  parameter int CLKDIV_W = 8,
  parameter int HOZ_W    = 11,
  parameter int LINE_W   = 10,
  parameter int BLANK_W  = 8,
  parameter int MVAL_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CLKDIV_W-1:0] raw_div,
  input  logic [HOZ_W-1:0]    raw_hcount,
  input  logic [LINE_W-1:0]   raw_vcount,
  input  logic [1:0]          raw_pulse,
  input  logic [1:0]          raw_delay,
  input  logic [BLANK_W-1:0]  raw_blank,
  input  logic                raw_mode,
  input  logic [MVAL_W-1:0]   raw_mval,
  output logic [CLKDIV_W-1:0] eff_div,
  output logic [HOZ_W-1:0]    eff_hcount,
  output logic [LINE_W-1:0]   eff_vcount,
  output logic [1:0]          eff_pulse,
  output logic [1:0]          eff_delay,
  output logic [BLANK_W-1:0]  eff_blank,
  output logic                eff_mode,
  output logic [MVAL_W-1:0]   eff_mval
);
  import stn_tg_pkg::*;

  logic [CLKDIV_W-1:0] sh_div;
  logic [HOZ_W-1:0]    sh_hcount;
  logic [LINE_W-1:0]   sh_vcount;
  logic [1:0]          sh_pulse;
  logic [1:0]          sh_delay;
  logic [BLANK_W-1:0]  sh_blank;
  logic                sh_mode;
  logic [MVAL_W-1:0]   sh_mval;

  logic [CLKDIV_W-1:0] sat_div;
  logic [MVAL_W-1:0]   sat_mval;

  assign sat_div  = CLKDIV_W'(sat_divisor(32'(raw_div)));
  assign sat_mval = MVAL_W'(sat_bias_lines(32'(raw_mval)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_div    <= CLKDIV_W'(2);
      sh_hcount <= '0;
      sh_vcount <= '0;
      sh_pulse  <= '0;
      sh_delay  <= '0;
      sh_blank  <= '0;
      sh_mode   <= 1'b0;
      sh_mval   <= MVAL_W'(1);
    end else if (load) begin
      sh_div    <= sat_div;
      sh_hcount <= raw_hcount;
      sh_vcount <= raw_vcount;
      sh_pulse  <= raw_pulse;
      sh_delay  <= raw_delay;
      sh_blank  <= raw_blank;
      sh_mode   <= raw_mode;
      sh_mval   <= sat_mval;
    end
  end

  // In the capture cycle the live inputs are used so the frame's first
  // cycle already follows the new setting.
  always_comb begin
    if (load) begin
      eff_div    = sat_div;
      eff_hcount = raw_hcount;
      eff_vcount = raw_vcount;
      eff_pulse  = raw_pulse;
      eff_delay  = raw_delay;
      eff_blank  = raw_blank;
      eff_mode   = raw_mode;
      eff_mval   = sat_mval;
    end else begin
      eff_div    = sh_div;
      eff_hcount = sh_hcount;
      eff_vcount = sh_vcount;
      eff_pulse  = sh_pulse;
      eff_delay  = sh_delay;
      eff_blank  = sh_blank;
      eff_mode   = sh_mode;
      eff_mval   = sh_mval;
    end
  end

endmodule

// File: rtl/stn_line_seq.sv
module stn_line_seq #(
  parameter int CLKDIV_W = 8,
  parameter int HOZ_W    = 11,
  parameter int BLANK_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CLKDIV_W-1:0] div,
  input  logic [HOZ_W-1:0]    hcount,
  input  logic [1:0]          pulse_code,
  input  logic [1:0]          delay_code,
  input  logic [BLANK_W-1:0]  blank,
  output logic                lpulse,
  output logic                pclk,
  output logic                active,
  output logic                line_end
);
  import stn_tg_pkg::*;

  localparam int PH_W  = (BLANK_W + 4 > 8) ? BLANK_W + 4 : 8;
  localparam int SUB_W = CLKDIV_W + 1;

  line_phase_e       ph;
  logic [PH_W-1:0]   cnt;
  logic [SUB_W-1:0]  sub;
  logic [HOZ_W-1:0]  pix;

  logic [PH_W-1:0]   plen_m1, dlen_m1, blen_m1;
  logic [SUB_W-1:0]  per_m1;
  logic              pulse_done, delay_done, per_done, act_done, blank_done, has_blank;

  assign plen_m1 = PH_W'(pulse_cycles(pulse_code) - 32'd1);
  assign dlen_m1 = PH_W'(delay_cycles(delay_code) - 32'd1);
  assign blen_m1 = PH_W'(blank_cycles(32'(blank)) - 32'd1);
  assign per_m1  = {div, 1'b0} - SUB_W'(1);

  assign has_blank  = (blank != '0);
  assign pulse_done = (ph == PH_PULSE)  && (cnt == plen_m1);
  assign delay_done = (ph == PH_DELAY)  && (cnt == dlen_m1);
  assign per_done   = (ph == PH_ACTIVE) && (sub == per_m1);
  assign act_done   = per_done && (pix == hcount);
  assign blank_done = (ph == PH_BLANK)  && (cnt == blen_m1);
  assign line_end   = blank_done || (act_done && !has_blank);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= PH_PULSE;
      cnt <= '0;
      sub <= '0;
      pix <= '0;
    end else begin
      unique case (ph)
        PH_PULSE: begin
          if (pulse_done) begin
            ph  <= PH_DELAY;
            cnt <= '0;
          end else begin
            cnt <= cnt + PH_W'(1);
          end
        end
        PH_DELAY: begin
          if (delay_done) begin
            ph  <= PH_ACTIVE;
            cnt <= '0;
            sub <= '0;
            pix <= '0;
          end else begin
            cnt <= cnt + PH_W'(1);
          end
        end
        PH_ACTIVE: begin
          if (per_done) begin
            sub <= '0;
            if (act_done) begin
              ph  <= has_blank ? PH_BLANK : PH_PULSE;
              cnt <= '0;
            end else begin
              pix <= pix + HOZ_W'(1);
            end
          end else begin
            sub <= sub + SUB_W'(1);
          end
        end
        PH_BLANK: begin
          if (blank_done) begin
            ph  <= PH_PULSE;
            cnt <= '0;
          end else begin
            cnt <= cnt + PH_W'(1);
          end
        end
        default: begin
          ph  <= PH_PULSE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign lpulse = (ph == PH_PULSE);
  assign active = (ph == PH_ACTIVE);
  assign pclk   = active && (sub >= {1'b0, div});

endmodule

// File: rtl/stn_frame_ctr.sv
module stn_frame_ctr #(
  parameter int LINE_W = 10,
  parameter int MVAL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic [LINE_W-1:0] vcount,
  input  logic              mode,
  input  logic [MVAL_W-1:0] mval,
  output logic              frm,
  output logic              bias,
  output logic              frame_start
);
  logic [LINE_W-1:0] line_idx;
  logic [MVAL_W-1:0] lc;
  logic              wrap, bias_hit;

  assign wrap     = (line_idx == vcount);
  assign bias_hit = (lc >= mval - MVAL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_idx    <= '0;
      frame_start <= 1'b1;
      bias        <= 1'b0;
      lc          <= '0;
    end else begin
      frame_start <= line_end && wrap;
      if (line_end) begin
        line_idx <= wrap ? '0 : line_idx + LINE_W'(1);
        if (mode) begin
          if (bias_hit) begin
            lc   <= '0;
            bias <= !bias;
          end else begin
            lc <= lc + MVAL_W'(1);
          end
        end else begin
          lc <= '0;
          if (wrap) bias <= !bias;
        end
      end
    end
  end

  assign frm = (line_idx == '0);

endmodule

// File: rtl/stn_timing_gen.sv
module stn_timing_gen #(
  parameter int CLKDIV_W = 8,
  parameter int HOZ_W    = 11,
  parameter int LINE_W   = 10,
  parameter int BLANK_W  = 8,
  parameter int MVAL_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CLKDIV_W-1:0] cfg_clkdiv,
  input  logic [HOZ_W-1:0]    cfg_hcount,
  input  logic [LINE_W-1:0]   cfg_vcount,
  input  logic [1:0]          cfg_pulse_code,
  input  logic [1:0]          cfg_delay_code,
  input  logic [BLANK_W-1:0]  cfg_blank,
  input  logic                cfg_bias_mode,
  input  logic [MVAL_W-1:0]   cfg_bias_lines,
  output logic                frame_o,
  output logic                line_o,
  output logic                pclk_o,
  output logic                bias_o,
  output logic                valid_o
);

  logic [CLKDIV_W-1:0] sh_div;
  logic [HOZ_W-1:0]    sh_hcount;
  logic [LINE_W-1:0]   sh_vcount;
  logic [1:0]          sh_pulse;
  logic [1:0]          sh_delay;
  logic [BLANK_W-1:0]  sh_blank;
  logic                sh_mode;
  logic [MVAL_W-1:0]   sh_mval;

  logic line_end;
  logic frame_start;

  stn_cfg_shadow #(
    .CLKDIV_W(CLKDIV_W), .HOZ_W(HOZ_W), .LINE_W(LINE_W),
    .BLANK_W(BLANK_W), .MVAL_W(MVAL_W)
  ) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (frame_start),
    .raw_div    (cfg_clkdiv),
    .raw_hcount (cfg_hcount),
    .raw_vcount (cfg_vcount),
    .raw_pulse  (cfg_pulse_code),
    .raw_delay  (cfg_delay_code),
    .raw_blank  (cfg_blank),
    .raw_mode   (cfg_bias_mode),
    .raw_mval   (cfg_bias_lines),
    .eff_div    (sh_div),
    .eff_hcount (sh_hcount),
    .eff_vcount (sh_vcount),
    .eff_pulse  (sh_pulse),
    .eff_delay  (sh_delay),
    .eff_blank  (sh_blank),
    .eff_mode   (sh_mode),
    .eff_mval   (sh_mval)
  );

  stn_line_seq #(
    .CLKDIV_W(CLKDIV_W), .HOZ_W(HOZ_W), .BLANK_W(BLANK_W)
  ) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .div        (sh_div),
    .hcount     (sh_hcount),
    .pulse_code (sh_pulse),
    .delay_code (sh_delay),
    .blank      (sh_blank),
    .lpulse     (line_o),
    .pclk       (pclk_o),
    .active     (valid_o),
    .line_end   (line_end)
  );

  stn_frame_ctr #(
    .LINE_W(LINE_W), .MVAL_W(MVAL_W)
  ) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_end    (line_end),
    .vcount      (sh_vcount),
    .mode        (sh_mode),
    .mval        (sh_mval),
    .frm         (frame_o),
    .bias        (bias_o),
    .frame_start (frame_start)
  );

endmodule

// File: rtl/stn_timing_gen_checker.sv
module stn_timing_gen_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       line_o,
  input logic       pclk_o,
  input logic       valid_o,
  input logic       frame_o,
  input logic       bias_o,
  input logic       line_end,
  input logic       frame_start,
  input logic [1:0] sh_pulse,
  input logic [1:0] sh_delay
);
  import stn_tg_pkg::*;

  logic [15:0] run_cnt;
  logic [15:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      gap_cnt <= '0;
    end else begin
      run_cnt <= line_o ? run_cnt + 16'd1 : 16'd0;
      gap_cnt <= line_o ? 16'd0 : (valid_o ? gap_cnt : gap_cnt + 16'd1);
    end
  end

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_o) |-> (run_cnt == 16'(pulse_cycles(sh_pulse))));

  assert_delay_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> (gap_cnt == 16'(delay_cycles(sh_delay))));

  assert_pclk_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> !pclk_o);

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !line_o);

  assert_frame_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_o != $past(frame_o)) |-> $past(line_end));

  assert_bias_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_o != $past(bias_o)) |-> $past(line_end));

  assert_capture_point_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (frame_o && line_o));

endmodule

bind stn_timing_gen stn_timing_gen_checker u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_o      (line_o),
  .pclk_o      (pclk_o),
  .valid_o     (valid_o),
  .frame_o     (frame_o),
  .bias_o      (bias_o),
  .line_end    (line_end),
  .frame_start (frame_start),
  .sh_pulse    (sh_pulse),
  .sh_delay    (sh_delay)
);

// File: tb/stn_timing_gen_test.sv
module stn_timing_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_clkdiv = 8'd3;
  logic [10:0] cfg_hcount = 11'd3;
  logic [9:0] cfg_vcount = 10'd3;
  logic [1:0] cfg_pulse_code = 2'd0;
  logic [1:0] cfg_delay_code = 2'd1;
  logic [7:0] cfg_blank = 8'd2;
  logic       cfg_bias_mode = 1'b0;
  logic [7:0] cfg_bias_lines = 8'd1;
  logic frame_o, line_o, pclk_o, bias_o, valid_o;

  always #2 clk = !clk;

  stn_timing_gen uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_clkdiv(cfg_clkdiv), .cfg_hcount(cfg_hcount), .cfg_vcount(cfg_vcount),
    .cfg_pulse_code(cfg_pulse_code), .cfg_delay_code(cfg_delay_code),
    .cfg_blank(cfg_blank), .cfg_bias_mode(cfg_bias_mode),
    .cfg_bias_lines(cfg_bias_lines),
    .frame_o(frame_o), .line_o(line_o), .pclk_o(pclk_o),
    .bias_o(bias_o), .valid_o(valid_o)
  );

  typedef struct {
    int pw; int ds; int dl; int rises; int hi; int tot;
    bit fr; bit bs; bit mode; bit r9;
  } item_t;

  typedef struct {
    int clkdiv; int hcount; int vcount; int pulse; int dly;
    int blank; bit mode; int mlines;
  } cfg_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int gk = 0;
  int fk = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: expected line shapes of one frame, computed from the rules.
  task automatic push_frame(input cfg_t c, input bit r9);
    int d  = (c.clkdiv < 2) ? 2 : c.clkdiv;
    int m  = (c.mlines == 0) ? 1 : c.mlines;
    int pw = 16 << c.pulse;
    int dw = 16 << c.dly;
    for (int l = 0; l <= c.vcount; l++) begin
      item_t e;
      e.pw    = pw;
      e.ds    = pw + dw;
      e.dl    = (c.hcount + 1) * 2 * d;
      e.rises = c.hcount + 1;
      e.hi    = (c.hcount + 1) * d;
      e.tot   = pw + dw + e.dl + 8 * c.blank;
      e.fr    = (l == 0);
      e.bs    = c.mode ? ((gk / m) % 2 == 1) : (fk % 2 == 1);
      e.mode  = c.mode;
      e.r9    = r9;
      q.push_back(e);
      gk++;
    end
    fk++;
  endtask

  task automatic apply(input cfg_t c);
    cfg_clkdiv     = 8'(c.clkdiv);
    cfg_hcount     = 11'(c.hcount);
    cfg_vcount     = 10'(c.vcount);
    cfg_pulse_code = 2'(c.pulse);
    cfg_delay_code = 2'(c.dly);
    cfg_blank      = 8'(c.blank);
    cfg_bias_mode  = c.mode;
    cfg_bias_lines = 8'(c.mlines);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    q.delete();
    gk = 0;
    fk = 0;
    repeat (2) @(negedge clk);
    chk(bias_o == 1'b0,  "R10", "bias in reset",  bias_o, 0);
    chk(pclk_o == 1'b0,  "R10", "pclk in reset",  pclk_o, 0);
    chk(valid_o == 1'b0, "R10", "valid in reset", valid_o, 0);
    chk(line_o == 1'b1,  "R10", "line in reset",  line_o, 1);
    chk(frame_o == 1'b1, "R10", "frame in reset", frame_o, 1);
  endtask

  task automatic release_reset();
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
  endtask

  // Monitor: measures each line from one line_o rise to the next.
  item_t m;
  bit    started = 0;
  bit    pline = 0, ppclk = 0;
  bit    fr_ok, bs_ok;
  int    t;

  task automatic compare(input item_t a, input item_t e, input bit fo, input bit bo);
    string bt = e.mode ? "R8" : "R7";
    chk(a.pw == e.pw,       "R3", "pulse width",  a.pw, e.pw);
    chk(a.ds == e.ds,       "R4", "active start", a.ds, e.ds);
    chk(a.dl == e.dl,       "R2", "active width", a.dl, e.dl);
    chk(a.rises == e.rises, "R1", "pclk rises",   a.rises, e.rises);
    chk(a.hi == e.hi,       "R1", "pclk high",    a.hi, e.hi);
    chk(a.tot == e.tot,     "R5", "line length",  a.tot, e.tot);
    chk(a.fr == e.fr,       "R6", "frame level",  a.fr, e.fr);
    chk(fo,                 "R6", "frame stable", 0, 1);
    chk(a.bs == e.bs,       bt,   "bias level",   a.bs, e.bs);
    chk(bo,                 bt,   "bias stable",  0, 1);
    if (e.r9) chk(a.tot == e.tot, "R9", "new setting line length", a.tot, e.tot);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      started = 0;
      pline = 0;
      ppclk = 0;
    end else begin
      if (line_o && !pline) begin
        if (started && q.size() > 0) compare(m, q.pop_front(), fr_ok, bs_ok);
        started = 1;
        m = '{pw: 0, ds: -1, dl: 0, rises: 0, hi: 0, tot: 0,
              fr: frame_o, bs: bias_o, mode: 0, r9: 0};
        fr_ok = 1;
        bs_ok = 1;
        t = 0;
      end
      if (started) begin
        if (line_o) m.pw++;
        if (valid_o) begin
          if (m.ds < 0) m.ds = t;
          m.dl++;
          if (pclk_o) m.hi++;
          if (pclk_o && !ppclk) m.rises++;
        end
        if (frame_o != m.fr) fr_ok = 0;
        if (bias_o != m.bs) bs_ok = 0;
        t++;
        m.tot = t;
      end
      pline = line_o;
      ppclk = pclk_o;
    end
  end

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cfg_t ca, cb, cc, cd;
    ca = '{clkdiv: 3, hcount: 3, vcount: 3, pulse: 0, dly: 1, blank: 2, mode: 0, mlines: 1};
    cb = '{clkdiv: 2, hcount: 5, vcount: 3, pulse: 1, dly: 0, blank: 0, mode: 0, mlines: 1};
    cc = '{clkdiv: 0, hcount: 2, vcount: 4, pulse: 3, dly: 3, blank: 1, mode: 1, mlines: 0};
    cd = '{clkdiv: 5, hcount: 0, vcount: 2, pulse: 2, dly: 2, blank: 3, mode: 1, mlines: 3};

    // Per-frame bias, then a change in the middle of a frame (R9)
    apply(ca);
    do_reset();
    push_frame(ca, 0);
    push_frame(ca, 0);
    release_reset();
    drain();
    @(posedge clk); #1;
    apply(cb);
    push_frame(ca, 0);
    push_frame(cb, 1);
    push_frame(cb, 1);
    drain();

    // Divisor 0 counts as 2, bias line count 0 counts as 1 (R1, R8)
    apply(cc);
    do_reset();
    push_frame(cc, 0);
    push_frame(cc, 0);
    push_frame(cc, 0);
    release_reset();
    drain();

    // Bias period of 3 lines across frames of 3 lines (R8)
    apply(cd);
    do_reset();
    push_frame(cd, 0);
    push_frame(cd, 0);
    push_frame(cd, 0);
    release_reset();
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule